// File: doc/BRIEF.md
# Merge-Split Successive-Approximation Conversion Controller

This block sequences one conversion of a 10-bit fully differential charge-redistribution ADC. The capacitor DAC is built differently from a plain binary array. On each side it has two identical sub-arrays, one preset to the supply and the other preset to ground. A bit is weighed by shorting or separating the bottom plates of a pair of like-sized capacitors, and a bottom plate is never moved from one reference to the other. The controller drives the sampling switch and the comparator clock, and it drives a 2-bit switch code for each capacitor pair. It assembles the decisions into an unsigned result.

A conversion starts when the sample clock rises. The controller samples while the sample clock is high. When it falls, the first comparison is launched with every pair still at its preset state, and that comparison gives the MSB. After that, the comparator's ready handshake paces the conversion. Each rising edge of ready is one finished decision. The decision is written straight into the switch code of the next pair, so the DAC gets the most time to settle. The comparator clock is raised again only once ready has returned low. After the LSB, the controller sleeps until the next sample and returns every switch code to the preset state. A watchdog ends a conversion whose comparator stops answering. The block runs on a fast reference clock, and the sample clock and ready are both seen through registered edge detection.

Top module: `msw_sar_ctrl`

## Requirements
- R1: After reset, samp_en, cmp_clk, done, result_valid and err are 0, result is 0 and every switch field is 00.
- R2: One cycle after a rising edge of sample_clk is seen, samp_en is 1, result is 0, done is 0 and all switch fields are 00. One cycle after the falling edge is seen, samp_en is 0 and cmp_clk is 1.
- R3: The first comparison runs with all switch fields at 00 (hold at preset), and its decision becomes result bit 9 (the MSB).
- R4: The clock edge that captures the MSB decision sets the field for the largest pair (sw_ctrl[17:16]) to 01 (merge) and leaves every other field unchanged.
- R5: For bits 8 down to 1, the edge that captures decision d sets the field of the next smaller pair (pair k-1 at sw_ctrl[2k-1:2k-2]). A d of 0 gives 01 (merge). A d of 1 gives a split: 10 (high half on the positive side) if the MSB was 1, or 11 (high half on the negative side) if the MSB was 0. No other field changes.
- R6: cmp_clk falls on the edge that captures a decision. It rises again only after cmp_rdy has been seen low, and each accepted ready rising edge resolves exactly one bit.
- R7: On the edge that captures the LSB, done goes to 1 and every switch field returns to 00. result_valid is 1 for exactly one cycle, and result holds the ten decisions with the first one at bit 9.
- R8: If cmp_clk stays high for 16 reference cycles with no ready rising edge, the conversion ends on the 16th edge. done, err and a one-cycle result_valid are set, the bits not yet resolved read 0, and all switch fields return to 00. A ready edge captured on that same 16th edge is accepted as a normal decision instead.
- R9: A ready rising edge while cmp_clk is low, for example during sleep, changes neither result nor the switch fields and raises no result_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_clk | input | 1 | Sample clock; rising edge starts sampling, falling edge starts conversion |
| cmp_dec | input | 1 | Comparator decision, valid when cmp_rdy rises |
| cmp_rdy | input | 1 | Comparator ready; a rising edge marks a finished decision |
| samp_en | output | 1 | Sampling-switch enable |
| cmp_clk | output | 1 | Comparator clock (high = compare) |
| sw_ctrl | output | 18 | Per-pair switch codes, pair i at bits [2i+1:2i]: 00 hold, 01 merge, 10 split high-positive, 11 split high-negative |
| result | output | 10 | Conversion result, MSB-first unsigned code |
| result_valid | output | 1 | One-cycle pulse when a conversion ends |
| done | output | 1 | Sleep/done flag, high from end of conversion until next sample |
| err | output | 1 | Set when the watchdog ended the conversion |

## Verification
Two functions of this block can fall in the same reference cycle: the capture of a decision and the expiry of the ready watchdog. When they coincide on the 16th cycle of a compare window, the decision must be taken and the timeout must not fire. The bench provokes this by running a whole conversion in which the comparator model holds off every ready edge so that it is captured on exactly that cycle. It judges the result by requiring the full correct code with err low. Separate runs let the window run out after 0, 3 and 9 answered bits. Those runs check that done is still low after 15 cycles, that done and err are high after 16, and that the unanswered bits read 0.

// File: rtl/msw_pkg.sv
package msw_pkg;

    // Bottom-plate action for one capacitor pair
    typedef enum logic [1:0] {
        SW_HOLD     = 2'b00,
        SW_MERGE    = 2'b01,
        SW_SPLIT_PH = 2'b10,
        SW_SPLIT_NH = 2'b11
    } sw_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV,
        ST_SLEEP
    } conv_state_e;

    // Action applied after a decision: the MSB always merges the top pair;
    // later bits merge on a 0 and split (polarity set by the MSB) on a 1.
    function automatic sw_code_e step_action(input logic first, input logic dec, input logic msb);
        if (first || !dec) return SW_MERGE;
        return msb ? SW_SPLIT_PH : SW_SPLIT_NH;
    endfunction

endpackage

// File: rtl/msw_edge_det.sv
module msw_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise[i] = din[i] & ~prev_q[i];
    end
endmodule

// File: rtl/msw_watchdog.sv
module msw_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !armed || kick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + CW'(1);
    end

    assign expired = armed && !kick && (cnt_q == LAST);
endmodule

// File: rtl/msw_switch_bank.sv
module msw_switch_bank
    import msw_pkg::*;
#(
    parameter int NPAIR = 9,
    parameter int IW    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 apply,
    input  logic [IW-1:0]        target,
    input  sw_code_e             code,
    output logic [2*NPAIR-1:0]   sw_ctrl
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        sw_code_e fld_q;

        always_ff @(posedge clk) begin
            if (rst || clear)                    fld_q <= SW_HOLD;
            else if (apply && target == IW'(i))  fld_q <= code;
        end

        assign sw_ctrl[2*i +: 2] = fld_q;
    end
endmodule

// File: rtl/msw_sar_ctrl.sv
module msw_sar_ctrl
    import msw_pkg::*;
#(
    parameter int N           = 10,
    parameter int WDOG_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_clk,
    input  logic                 cmp_dec,
    input  logic                 cmp_rdy,
    output logic                 samp_en,
    output logic                 cmp_clk,
    output logic [2*(N-1)-1:0]   sw_ctrl,
    output logic [N-1:0]         result,
    output logic                 result_valid,
    output logic                 done,
    output logic                 err
);
    localparam int NPAIR = N - 1;
    localparam int IW    = $clog2(N);
    localparam logic [IW-1:0] TOP_IDX  = IW'(N - 1);
    localparam logic [IW-1:0] TOP_PAIR = IW'(N - 2);

    // Edge detection: sample rise, sample fall, ready rise
    logic [2:0] edge_in, edge_rise;
    logic       samp_rise, samp_fall, rdy_rise;

    assign edge_in = {cmp_rdy, ~sample_clk, sample_clk};

    msw_edge_det #(.W(3)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (edge_in),
        .rise (edge_rise)
    );

    assign samp_rise = edge_rise[0];
    assign samp_fall = edge_rise[1];
    assign rdy_rise  = edge_rise[2];

    conv_state_e   state_q;
    logic [IW-1:0] idx_q;
    logic          cmp_clk_q;
    logic [N-1:0]  res_q;
    logic          valid_q;
    logic          err_q;

    logic armed, accept, last_bit, first_bit, wd_expired;

    assign armed     = (state_q == ST_CONV) && cmp_clk_q;
    assign accept    = armed && rdy_rise;
    assign last_bit  = (idx_q == '0);
    assign first_bit = (idx_q == TOP_IDX);

    msw_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .armed   (armed),
        .kick    (rdy_rise),
        .expired (wd_expired)
    );

    // Switch step derived from the decision arriving this cycle
    logic          msb_ref;
    sw_code_e      step_code;
    logic [IW-1:0] step_pair;
    logic          sw_apply, sw_clear;

    assign msb_ref   = first_bit ? cmp_dec : res_q[N-1];
    assign step_code = step_action(first_bit, cmp_dec, msb_ref);
    assign step_pair = first_bit ? TOP_PAIR : (idx_q - IW'(1));
    assign sw_apply  = accept && !last_bit;
    assign sw_clear  = samp_rise || (accept && last_bit) || wd_expired;

    msw_switch_bank #(.NPAIR(NPAIR), .IW(IW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clear   (sw_clear),
        .apply   (sw_apply),
        .target  (step_pair),
        .code    (step_code),
        .sw_ctrl (sw_ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            cmp_clk_q <= 1'b0;
            res_q     <= '0;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (samp_rise) begin
                state_q   <= ST_SAMPLE;
                cmp_clk_q <= 1'b0;
                res_q     <= '0;
                err_q     <= 1'b0;
            end else begin
                case (state_q)
                    ST_SAMPLE: begin
                        if (samp_fall) begin
                            state_q   <= ST_CONV;
                            idx_q     <= TOP_IDX;
                            cmp_clk_q <= 1'b1;
                        end
                    end
                    ST_CONV: begin
                        if (accept) begin
                            for (int b = 0; b < N; b++) begin
                                if (idx_q == IW'(b)) res_q[b] <= cmp_dec;
                            end
                            cmp_clk_q <= 1'b0;
                            if (last_bit) begin
                                state_q <= ST_SLEEP;
                                valid_q <= 1'b1;
                            end else begin
                                idx_q <= idx_q - IW'(1);
                            end
                        end else if (wd_expired) begin
                            state_q   <= ST_SLEEP;
                            cmp_clk_q <= 1'b0;
                            valid_q   <= 1'b1;
                            err_q     <= 1'b1;
                        end else if (!cmp_clk_q && !cmp_rdy) begin
                            cmp_clk_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign samp_en      = (state_q == ST_SAMPLE);
    assign cmp_clk      = cmp_clk_q;
    assign result       = res_q;
    assign result_valid = valid_q;
    assign done         = (state_q == ST_SLEEP);
    assign err          = err_q;
endmodule

// File: rtl/msw_sar_ctrl_chk.sv
module msw_sar_ctrl_chk #(
    parameter int N = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               samp_en,
    input logic               cmp_clk,
    input logic               cmp_rdy,
    input logic [2*(N-1)-1:0] sw_ctrl,
    input logic [N-1:0]       result,
    input logic               result_valid,
    input logic               done,
    input logic               err
);
    // R2
    samp_clean_chk: assert property (@(posedge clk) disable iff (rst)
        samp_en |-> (sw_ctrl == '0 && result == '0 && !cmp_clk));

    // R6
    rearm_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmp_clk) && !$past(samp_en)) |-> !$past(cmp_rdy));

    // R6
    no_compare_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmp_clk);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R7
    sleep_preset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (sw_ctrl == '0 && result_valid));

    // R8
    err_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R8
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> result_valid);
endmodule

bind msw_sar_ctrl msw_sar_ctrl_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .samp_en      (samp_en),
    .cmp_clk      (cmp_clk),
    .cmp_rdy      (cmp_rdy),
    .sw_ctrl      (sw_ctrl),
    .result       (result),
    .result_valid (result_valid),
    .done         (done),
    .err          (err)
);

// File: tb/tb_msw_sar_ctrl.sv
module tb_msw_sar_ctrl;
    localparam int N  = 10;
    localparam int SW = 2 * (N - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_clk = 1'b0;
    logic cmp_dec = 1'b0;
    logic cmp_rdy = 1'b0;
    logic samp_en, cmp_clk, result_valid, done, err;
    logic [SW-1:0] sw_ctrl;
    logic [N-1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    msw_sar_ctrl #(.N(N), .WDOG_CYCLES(16)) dut (
        .clk          (clk),
        .rst          (rst),
        .sample_clk   (sample_clk),
        .cmp_dec      (cmp_dec),
        .cmp_rdy      (cmp_rdy),
        .samp_en      (samp_en),
        .cmp_clk      (cmp_clk),
        .sw_ctrl      (sw_ctrl),
        .result       (result),
        .result_valid (result_valid),
        .done         (done),
        .err          (err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Expected switch code for the pair set after bit k's decision
    function automatic logic [1:0] exp_code(input int k, input logic d, input logic msb);
        if (k == N - 1 || !d) return 2'b01;
        return msb ? 2'b10 : 2'b11;
    endfunction

    // One conversion. delay<0: random response delay; nans: bits answered before silence
    task automatic convert(input logic [N-1:0] vin, input int delay, input int nans);
        logic [SW-1:0] exp_sw;
        logic          msb;
        int            guard;
        exp_sw = '0;
        msb    = 1'b0;
        @(negedge clk);
        sample_clk = 1'b1;
        @(negedge clk);
        chk(samp_en == 1'b1 && done == 1'b0, "R2 samp_en", samp_en, 1);
        chk(result == '0 && sw_ctrl == '0, "R2 cleared", {result, sw_ctrl}, 0);
        sample_clk = 1'b0;
        @(negedge clk);
        chk(samp_en == 1'b0 && cmp_clk == 1'b1, "R2 compare start", {samp_en, cmp_clk}, 1);
        chk(sw_ctrl == '0, "R3 first compare unswitched", sw_ctrl, 0);
        for (int k = N - 1; k >= 0; k--) begin
            guard = 0;
            while (!cmp_clk && guard < 8) begin
                @(negedge clk);
                guard++;
            end
            chk(cmp_clk == 1'b1, "R6 rearm", cmp_clk, 1);
            if (N - 1 - k == nans) begin
                repeat (15) @(negedge clk);
                chk(done == 1'b0, "R8 not before 16", done, 0);
                @(negedge clk);
                chk(done && err && result_valid, "R8 timeout flags", {done, err, result_valid}, 7);
                chk(result == (vin & ~((N'(1) << (N - nans)) - N'(1))) || (nans == 0 && result == '0),
                    "R8 missing bits zero", result, vin);
                chk(sw_ctrl == '0 && cmp_clk == 1'b0, "R8 switches preset", sw_ctrl, 0);
                @(negedge clk);
                chk(result_valid == 1'b0, "R8 valid single", result_valid, 0);
                return;
            end
            if (delay < 0) repeat ($urandom_range(0, 3)) @(negedge clk);
            else           repeat (delay) @(negedge clk);
            cmp_dec = vin[k];
            cmp_rdy = 1'b1;
            if (k == N - 1) msb = vin[k];
            if (k > 0) exp_sw[2*(k == N - 1 ? N - 2 : k - 1) +: 2] = exp_code(k, vin[k], msb);
            else       exp_sw = '0;
            @(negedge clk);
            chk(cmp_clk == 1'b0, "R6 clock drops on capture", cmp_clk, 0);
            if (k == N - 1) chk(sw_ctrl == exp_sw, "R4 merge top pair", sw_ctrl, exp_sw);
            else if (k > 0) chk(sw_ctrl == exp_sw, "R5 step code", sw_ctrl, exp_sw);
            else begin
                chk(sw_ctrl == '0, "R7 switches preset", sw_ctrl, 0);
                chk(done && result_valid && !err, "R7 done flags", {done, result_valid, err}, 6);
                chk(result == vin, "R7 result", result, vin);
            end
            if (delay < 0) begin
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    chk(cmp_clk == 1'b0, "R6 held low while ready", cmp_clk, 0);
                end
            end
            cmp_rdy = 1'b0;
            if (k == 0) begin
                @(negedge clk);
                chk(result_valid == 1'b0 && done == 1'b1, "R7 valid single", result_valid, 0);
            end
        end
    endtask

    initial begin
        logic [N-1:0] hold;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(samp_en == 0 && cmp_clk == 0 && done == 0 && result_valid == 0 && err == 0,
            "R1 reset flags", {samp_en, cmp_clk, done, result_valid, err}, 0);
        chk(result == '0 && sw_ctrl == '0, "R1 reset data", {result, sw_ctrl}, 0);
        rst = 1'b0;
        @(negedge clk);

        convert(10'd0,    -1, N + 1);
        convert(10'd1023, -1, N + 1);
        convert(10'd512,  -1, N + 1);
        convert(10'd511,  -1, N + 1);
        // Ready captured on the last watchdog cycle: decision wins (R8)
        convert(10'd613,  15, N + 1);
        chk(err == 1'b0 && result == 10'd613, "R8 ready on 16th edge", result, 613);
        for (int i = 0; i < 40; i++) convert(N'($urandom_range(0, 1023)), -1, N + 1);

        // Watchdog expiries after 0, 3 and 9 answered bits
        convert(10'd777, -1, 0);
        convert(10'd777, -1, 3);
        convert(10'd345, -1, 9);

        // R9: ready edge in sleep is ignored
        convert(10'd300, -1, N + 1);
        hold = result;
        @(negedge clk);
        cmp_dec = 1'b1;
        cmp_rdy = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(result == hold && sw_ctrl == '0 && !result_valid && done && !cmp_clk,
                "R9 sleep ready ignored", result, hold);
        end
        cmp_rdy = 1'b0;
        repeat (2) @(negedge clk);
        chk(result == hold, "R9 result kept", result, hold);

        finish_run();
    end
endmodule